// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block tells the command arbiter of a DDR SDRAM controller when to issue an AUTO REFRESH. A free-running divider counts controller clocks and marks one refresh as owed at each average interval. The average interval is 7.8125 µs for the higher-density device option and 15.625 µs for the lower-density one, which together cover every row within 64 ms. Each interval is converted to clock cycles from a clock-frequency parameter.

The arbiter can give a busy hint, and while it does, owed refreshes are held back so that traffic in flight can finish. The backlog is capped at eight. When the backlog reaches the cap, the request becomes urgent and the busy hint no longer suppresses it. A second counter measures the time since the last granted refresh. When that time comes within a guard margin of the absolute maximum spacing (70.3 µs dense, 140.6 µs sparse), the request is also made urgent, whatever the backlog.

A refresh is taken in the cycle where the request and the grant are both high. From that cycle on, the clock-enable hold output stays high for the refresh duration. No new request is raised until that duration has passed.

Top module: `refresh_scheduler`

## Requirements
- R1: One refresh becomes owed every AVG cycles, where AVG = floor(CLK_MHZ*78125/10000) when HIGH_DENSITY=1 and floor(CLK_MHZ*15625/1000) otherwise. After reset, with no busy hint, `rfsh_req` first rises after exactly AVG clock edges.
- R2: `rfsh_req` is high whenever no refresh is running, at least one refresh is owed and `busy_hint` is low.
- R3: While `busy_hint` is high, `rfsh_req` stays low unless `rfsh_urgent` is high.
- R4: The owed count saturates at OWED_MAX (8). While it equals OWED_MAX, `rfsh_urgent` is high and `rfsh_req` is raised whenever no refresh is running, even with `busy_hint` high.
- R5: `rfsh_urgent` is high once the number of cycles since the last granted refresh, or since reset, reaches HARD-GUARD_CYC. HARD is floor(CLK_MHZ*703/10) when dense and floor(CLK_MHZ*1406/10) otherwise. This holds regardless of the owed count.
- R6: A refresh is granted only in a cycle where `rfsh_req` and `rfsh_gnt` are both high. The grant lowers the owed count by one (never below zero) and restarts the spacing counter. `rfsh_gnt` with `rfsh_req` low has no effect.
- R7: `cke_hold` is high in the grant cycle and in the following TRFC_CYC-1 cycles. `rfsh_req` stays low during those following cycles.
- R8: A synchronous reset clears the owed count, the spacing counter and the refresh timer. After the reset, `rfsh_req`, `rfsh_urgent` and `cke_hold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| busy_hint | input | 1 | Arbiter asks to defer non-urgent refreshes |
| rfsh_gnt | input | 1 | Arbiter issues the AUTO REFRESH this cycle |
| rfsh_req | output | 1 | Refresh request toward the arbiter |
| rfsh_urgent | output | 1 | Request may not be deferred any longer |
| cke_hold | output | 1 | Keep clock enable high while a refresh runs |

## Verification
The bench holds the busy hint with no grants for long stretches so that the backlog fills. If the cap were missing, the count would wrap and the urgent request would vanish. If the cap were off by one, the urgent request would rise one interval late. A separate run from reset holds the busy hint until the spacing counter trips while only seven refreshes are owed, which exposes a design that makes urgency depend on the backlog alone. The bench also grants in the same cycle as an interval tick, and grants with no refresh owed when the spacing limit forces one. It pulses the grant while no request is up. A design that miscounted the owed refreshes, underflowed the count, or accepted a bare grant would then drift from the bench's own model in the request, urgent and clock-enable outputs.

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int CLK_MHZ      = 133,
  parameter bit HIGH_DENSITY = 1'b1,
  parameter int TRFC_CYC     = 10,
  parameter int GUARD_CYC    = 64,
  parameter int OWED_MAX     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_hint,
  input  logic rfsh_gnt,
  output logic rfsh_req,
  output logic rfsh_urgent,
  output logic cke_hold
);

  localparam int AVG_CYC  = HIGH_DENSITY ? (CLK_MHZ * 78125) / 10000
                                         : (CLK_MHZ * 15625) / 1000;
  localparam int HARD_CYC = HIGH_DENSITY ? (CLK_MHZ * 703) / 10
                                         : (CLK_MHZ * 1406) / 10;
  localparam int TRIP_CYC = HARD_CYC - GUARD_CYC;
  localparam int AW = $clog2(AVG_CYC);
  localparam int WW = $clog2(HARD_CYC + 1);
  localparam int RW = $clog2(TRFC_CYC);
  localparam int OW = $clog2(OWED_MAX + 1);

  logic [AW-1:0] div_q;
  logic [OW-1:0] owed_q, owed_d;
  logic [WW-1:0] gap_q;
  logic [RW-1:0] busy_q;
  logic [OW:0]   owed_sum;
  logic          tick, fire, idle, dec;

  assign tick        = div_q == AW'(AVG_CYC - 1);
  assign idle        = busy_q == '0;
  assign rfsh_urgent = (owed_q == OW'(OWED_MAX)) || (gap_q >= WW'(TRIP_CYC));
  assign rfsh_req    = idle && (rfsh_urgent || (owed_q != '0 && !busy_hint));
  assign fire        = rfsh_req && rfsh_gnt;
  assign cke_hold    = fire || !idle;
  assign dec         = fire && (owed_q != '0);

  always_comb begin
    owed_sum = {1'b0, owed_q} + (OW+1)'(tick) - (OW+1)'(dec);
    owed_d   = (owed_sum > (OW+1)'(OWED_MAX)) ? OW'(OWED_MAX) : owed_sum[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      owed_q <= '0;
      gap_q  <= '0;
      busy_q <= '0;
    end else begin
      div_q  <= tick ? '0 : div_q + 1'b1;
      owed_q <= owed_d;
      if (fire)
        gap_q <= '0;
      else if (gap_q != WW'(HARD_CYC))
        gap_q <= gap_q + 1'b1;
      if (fire)
        busy_q <= RW'(TRFC_CYC - 1);
      else if (!idle)
        busy_q <= busy_q - 1'b1;
    end
  end

endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk #(
  parameter int CLK_MHZ      = 133,
  parameter bit HIGH_DENSITY = 1'b1,
  parameter int TRFC_CYC     = 10,
  parameter int GUARD_CYC    = 64
) (
  input logic clk,
  input logic rst,
  input logic busy_hint,
  input logic rfsh_gnt,
  input logic rfsh_req,
  input logic rfsh_urgent,
  input logic cke_hold
);

  localparam int HARD = HIGH_DENSITY ? (CLK_MHZ * 703) / 10 : (CLK_MHZ * 1406) / 10;
  localparam int TRIP = HARD - GUARD_CYC;

  int   since_q;
  logic granted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q   <= 0;
      granted_q <= 1'b0;
    end else if (rfsh_req && rfsh_gnt) begin
      since_q   <= 0;
      granted_q <= 1'b1;
    end else if (since_q < HARD) begin
      since_q   <= since_q + 1;
    end
  end

  assert_busy_defers_R3: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && busy_hint) |-> rfsh_urgent);

  assert_gap_trip_R5: assert property (@(posedge clk) disable iff (rst)
    (since_q >= TRIP) |-> rfsh_urgent);

  assert_urgent_raises_R4: assert property (@(posedge clk) disable iff (rst)
    (rfsh_urgent && !cke_hold) |-> rfsh_req);

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && rfsh_gnt) |-> cke_hold);

  assert_hold_window_R7: assert property (@(posedge clk) disable iff (rst)
    (granted_q && since_q < TRFC_CYC - 1) |-> (cke_hold && !rfsh_req));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!rfsh_req && !rfsh_urgent && !cke_hold));

endmodule

bind refresh_scheduler refresh_scheduler_chk #(
  .CLK_MHZ(CLK_MHZ), .HIGH_DENSITY(HIGH_DENSITY),
  .TRFC_CYC(TRFC_CYC), .GUARD_CYC(GUARD_CYC)
) chk_i (
  .clk(clk), .rst(rst), .busy_hint(busy_hint), .rfsh_gnt(rfsh_gnt),
  .rfsh_req(rfsh_req), .rfsh_urgent(rfsh_urgent), .cke_hold(cke_hold)
);

// File: tb/refresh_scheduler_tb_top.sv
module refresh_scheduler_tb_top;
  localparam int MHZ   = 8;
  localparam int TRFC  = 4;
  localparam int GUARD = 100;
  localparam int OMAX  = 8;
  localparam int AVG   = (MHZ * 78125) / 10000;
  localparam int HARD  = (MHZ * 703) / 10;
  localparam int TRIP  = HARD - GUARD;

  logic clk = 1'b0, rst = 1'b1, busy = 1'b0, gnt = 1'b0;
  logic req, urg, cke;
  int n_chk = 0, n_bad = 0;
  int m_div = 0, m_owed = 0, m_gap = 0, m_rfc = 0;
  int m_fires = 0, d_fires = 0;
  logic last_req, last_urg, last_cke;

  always #4 clk = ~clk;

  refresh_scheduler #(
    .CLK_MHZ(MHZ), .HIGH_DENSITY(1'b1), .TRFC_CYC(TRFC),
    .GUARD_CYC(GUARD), .OWED_MAX(OMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .busy_hint(busy), .rfsh_gnt(gnt),
    .rfsh_req(req), .rfsh_urgent(urg), .cke_hold(cke)
  );

  function automatic bit exp_urg();
    return (m_owed == OMAX) || (m_gap >= TRIP);
  endfunction

  function automatic bit exp_req(input bit b);
    return (m_rfc == 0) && (exp_urg() || (m_owed != 0 && !b));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit b, input bit g, input bit r);
    bit f;
    @(negedge clk);
    busy = b; gnt = g; rst = r;
    #1;
    last_req = req; last_urg = urg; last_cke = cke;
    chk("R2/R3 request", req, exp_req(b));
    chk("R4/R5 urgent", urg, exp_urg());
    chk("R7 cke hold", cke, (exp_req(b) && g) || m_rfc != 0);
    f = exp_req(b) && g;
    if (f) m_fires++;
    if (req && g) d_fires++;
    @(posedge clk);
    if (r) begin
      m_div = 0; m_owed = 0; m_gap = 0; m_rfc = 0;
    end else begin
      bit t;
      t = (m_div == AVG - 1);
      m_div = t ? 0 : m_div + 1;
      m_owed = m_owed + int'(t) - int'(f && m_owed > 0);
      if (m_owed > OMAX) m_owed = OMAX;
      m_gap = f ? 0 : (m_gap < HARD ? m_gap + 1 : m_gap);
      m_rfc = f ? TRFC - 1 : (m_rfc != 0 ? m_rfc - 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) cycle(1'b0, 1'b0, 1'b1);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R8 reset request", last_req, 0);
    chk("R8 reset cke", last_cke, 0);
    chk("R8 reset urgent", last_urg, 0);

    // R1 first request after AVG edges; R6 stray grants before it are ignored
    for (int i = 1; i <= AVG; i++) begin
      cycle(1'b0, i < AVG, 1'b0);
      if (i < AVG) chk("R6 stray grant cke", last_cke, 0);
      chk("R1 first request", last_req, i == AVG);
    end
    cycle(1'b0, 1'b1, 1'b0);
    chk("R6 grant taken", last_cke, 1);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R7 no request while refreshing", last_req, 0);

    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 4) == 0, ($urandom % 2) == 0, 1'b0);
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 8) != 0, ($urandom % 3) == 0, 1'b0);

    // R4 saturation: busy and no grants, then drain under busy
    for (int i = 0; i < 800; i++) cycle(1'b1, 1'b0, 1'b0);
    chk("R4 urgent after saturation", last_urg, 1);
    chk("R4 request despite busy", last_req, 1);
    m_fires = 0; d_fires = 0;
    for (int i = 0; i < 60; i++) cycle(1'b1, 1'b1, 1'b0);
    chk("R4 drained refresh count", d_fires, m_fires);

    // R5 spacing limit trips with only seven owed
    cycle(1'b0, 1'b0, 1'b1);
    for (int i = 0; i <= TRIP + 5; i++) begin
      cycle(1'b1, 1'b0, 1'b0);
      if (i == TRIP - 1 || i == TRIP)
        chk("R5 spacing trip", last_urg, i >= TRIP);
    end
    chk("R5 request while busy", last_req, 1);
    cycle(1'b1, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 1'b0);
    chk("R5 urgent cleared by grant", last_urg, 0);

    // R8 reset in the middle of traffic
    for (int i = 0; i < 500; i++)
      cycle(($urandom % 3) == 0, ($urandom % 2) == 0, 1'b0);
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b0);
    chk("R8 mid-run reset request", last_req, 0);
    chk("R8 mid-run reset cke", last_cke, 0);
    for (int i = 0; i < 2000; i++)
      cycle(($urandom % 2) == 0, ($urandom % 4) == 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule